// File: doc/BRIEF.md
# Image Trailer CRC-16 Checker

This block checks the integrity of a firmware image as it streams past, one byte per valid beat. The image carries its own checksum in its last two bytes. The block computes a 16-bit CRC over every byte that comes before those two. It captures the two trailing bytes as the expected value. When the beat marked as last arrives, the block reports whether the two values agree. The image is not stored, and its headers are not parsed.

Bytes pass through a short delay line that is as deep as the checksum. A byte enters the CRC only once a newer byte has pushed it out of the line. By then it is certain that the byte is not part of the trailer, so the trailer never reaches the CRC. The block is always ready to accept data. A synchronous start input abandons a partial image, and the beat after a last beat opens a new image without any start. An image that is too short to hold a trailer and at least one payload byte is reported as malformed.

Top module: `img_crc_check`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset; the block never applies back-pressure.
- R2: `crc_calc` reports the CRC of all image bytes except the final two. The CRC uses generator 0x1021, starts from 0x0000 and shifts each byte in most significant bit first, with no final inversion. For example, the ASCII string "123456789" gives 0x31C3.
- R3: `crc_expect` reports the final two bytes of the image. The earlier of the two is the high byte, at bits 15:8.
- R4: `done` is high for the one cycle that follows the clock edge at which a beat with `in_valid` and `in_last` both high is accepted. It is low at all other times.
- R5: at done, `match` is 1 exactly when the image is not malformed and `crc_calc` equals `crc_expect`; a mismatch gives `match` = 0.
- R6: an image of one or two bytes sets `malformed` = 1 and `match` = 0, with `crc_calc` = 0x0000. `crc_expect` holds the bytes present, with the earlier byte high; for a one-byte image the high byte is 0x00.
- R7: cycles with `in_valid` low are ignored; idle gaps inside an image do not change its result.
- R8: a cycle with `start` high drops any partial image and clears `match`, `malformed`, `crc_calc` and `crc_expect` to 0. A beat accepted in the same cycle as `start` counts as the first byte of the new image.
- R9: `match`, `malformed`, `crc_calc` and `crc_expect` keep their values until the next done or start.
- R10: the beat after a last beat begins a new image with no `start` needed, even in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Drops any partial image and clears the results |
| in_valid | input | 1 | A byte is offered on `in_data` this cycle |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Always 1 |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| match | output | 1 | Computed CRC equals the stored trailer |
| malformed | output | 1 | Image was shorter than three bytes |
| crc_calc | output | 16 | CRC computed over the payload |
| crc_expect | output | 16 | Trailer value, earlier byte high |

## Verification
The main check uses the known string "123456789" with its correct trailer 0x31C3, then with the trailer bytes swapped. The swapped case shows whether byte order and CRC direction are both right. Images of one, two and three bytes test the length boundary; an all-zero two-byte image must still be malformed even though its CRC and trailer agree. Random images with random or correct trailers are also used, some sent with idle gaps and some sent back to back, and a start pulse is applied both alone and together with a first byte. Together these separate a wrong delay depth, trailer bytes folded into the CRC, and leftover state from an earlier image.

// File: rtl/icc_pkg.sv
// Package: shared sizes for the image trailer CRC checker.
// Assumes byte-wide beats and a 16-bit checksum by default.
package icc_pkg;
    localparam int unsigned ICC_BYTE_W = 8;
    localparam int unsigned ICC_CRC_W  = 16;
    localparam logic [ICC_CRC_W-1:0] ICC_POLY = 16'h1021;
    localparam logic [ICC_CRC_W-1:0] ICC_INIT = 16'h0000;
endpackage

// File: rtl/icc_tail_delay.sv
// Module: icc_tail_delay
// Holds the TAIL_N newest bytes of the image. A byte spills out toward the CRC
// only when a newer byte arrives while the line is full, so the trailer never
// leaves. Presents the trailer word (earlier byte high) built from the held bytes
// and the current beat. Assumes clear (start) takes effect before the beat of
// the same cycle.
module icc_tail_delay #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned TAIL_N = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     beat,
    input  logic                     last,
    input  logic [BYTE_W-1:0]        data,
    output logic                     spill_valid,
    output logic [BYTE_W-1:0]        spill_byte,
    output logic                     short_img,
    output logic [TAIL_N*BYTE_W-1:0] tail_word
);
    localparam int unsigned FILL_W = $clog2(TAIL_N + 1);

    logic [BYTE_W-1:0] hold_q [TAIL_N];
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] base_fill;
    logic              full;

    // Effective fill level once a same-cycle clear is applied.
    assign base_fill   = clear ? '0 : fill_q;
    assign full        = (base_fill == FILL_W'(TAIL_N));
    assign spill_valid = beat && full;
    assign spill_byte  = hold_q[TAIL_N-1];
    assign short_img   = !full;

    // Fill level: saturates at TAIL_N, empties after the last byte or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (beat && last) begin
            fill_q <= '0;
        end else if (beat) begin
            fill_q <= full ? base_fill : base_fill + FILL_W'(1);
        end else if (clear) begin
            fill_q <= '0;
        end
    end

    genvar j;
    generate
        for (j = 0; j < TAIL_N; j++) begin : g_slot
            // Slot j: newest byte at slot 0, each beat shifts toward the end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q[j] <= '0;
                end else if (beat && last) begin
                    hold_q[j] <= '0;
                end else if (beat) begin
                    if (j == 0) begin
                        hold_q[j] <= data;
                    end else begin
                        hold_q[j] <= hold_q[(j == 0) ? 0 : j-1];
                    end
                end else if (clear) begin
                    hold_q[j] <= '0;
                end
            end
        end

        for (j = 0; j + 1 < TAIL_N; j++) begin : g_tail
            // Trailer byte above the current beat, zero when not yet received.
            assign tail_word[(j+1)*BYTE_W +: BYTE_W] =
                (base_fill > FILL_W'(j)) ? hold_q[j] : '0;
        end
    endgenerate

    // The current beat is always the lowest trailer byte.
    assign tail_word[BYTE_W-1:0] = data;
endmodule

// File: rtl/icc_crc_engine.sv
// Module: icc_crc_engine
// Running CRC register, one byte per feed, shifted most significant bit first.
// crc_final is the value including this cycle's feed, used by the verdict.
// Assumes restart (end of image) overrides feed for the register update.
module icc_crc_engine #(
    parameter int unsigned          BYTE_W = 8,
    parameter int unsigned          CRC_W  = 16,
    parameter logic [CRC_W-1:0]     POLY   = 16'h1021,
    parameter logic [CRC_W-1:0]     INIT   = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              restart,
    input  logic              feed,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_final
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    // Advance a CRC value by one byte, MSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i]) r = (r << 1) ^ POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction

    // Value before this cycle's byte, after any same-cycle clear.
    assign crc_base  = clear ? INIT : crc_q;
    assign crc_final = feed ? crc_step(crc_base, byte_in) : crc_base;

    // CRC register: reseeds at image end, otherwise tracks crc_final.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= INIT;
        else if (restart) crc_q <= INIT;
        else              crc_q <= crc_final;
    end
endmodule

// File: rtl/icc_verdict.sv
// Module: icc_verdict
// Latches the result when the last byte is accepted and pulses done for one
// cycle. Results hold until the next image end or a start.
module icc_verdict #(
    parameter int unsigned CRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic             short_img,
    input  logic [CRC_W-1:0] crc_final,
    input  logic [CRC_W-1:0] tail_word,
    output logic             done,
    output logic             match,
    output logic             malformed,
    output logic [CRC_W-1:0] crc_calc,
    output logic [CRC_W-1:0] crc_expect
);
    // Result registers: capture on fire, clear on start, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            match      <= 1'b0;
            malformed  <= 1'b0;
            crc_calc   <= '0;
            crc_expect <= '0;
        end else if (fire) begin
            done       <= 1'b1;
            malformed  <= short_img;
            match      <= !short_img && (crc_final == tail_word);
            crc_calc   <= crc_final;
            crc_expect <= tail_word;
        end else if (clear) begin
            done       <= 1'b0;
            match      <= 1'b0;
            malformed  <= 1'b0;
            crc_calc   <= '0;
            crc_expect <= '0;
        end else begin
            done       <= 1'b0;
        end
    end
endmodule

// File: rtl/img_crc_check.sv
// Module: img_crc_check (top)
// Streaming firmware-image checker: CRC over all bytes but the last two, which
// are compared against it as a big-endian trailer. Always ready. Assumes
// CRC_W is a whole number of bytes.
module img_crc_check #(
    parameter int unsigned      BYTE_W = icc_pkg::ICC_BYTE_W,
    parameter int unsigned      CRC_W  = icc_pkg::ICC_CRC_W,
    parameter logic [CRC_W-1:0] POLY   = icc_pkg::ICC_POLY,
    parameter logic [CRC_W-1:0] INIT   = icc_pkg::ICC_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              done,
    output logic              match,
    output logic              malformed,
    output logic [CRC_W-1:0]  crc_calc,
    output logic [CRC_W-1:0]  crc_expect
);
    localparam int unsigned TAIL_N = CRC_W / BYTE_W;

    logic              fire;
    logic              spill_valid;
    logic [BYTE_W-1:0] spill_byte;
    logic              short_img;
    logic [CRC_W-1:0]  tail_word;
    logic [CRC_W-1:0]  crc_final;

    assign in_ready = 1'b1;
    assign fire     = in_valid && in_last;

    icc_tail_delay #(.BYTE_W(BYTE_W), .TAIL_N(TAIL_N)) u_tail (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .beat        (in_valid),
        .last        (in_last),
        .data        (in_data),
        .spill_valid (spill_valid),
        .spill_byte  (spill_byte),
        .short_img   (short_img),
        .tail_word   (tail_word)
    );

    icc_crc_engine #(.BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .restart   (fire),
        .feed      (spill_valid),
        .byte_in   (spill_byte),
        .crc_final (crc_final)
    );

    icc_verdict #(.CRC_W(CRC_W)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .fire       (fire),
        .short_img  (short_img),
        .crc_final  (crc_final),
        .tail_word  (tail_word),
        .done       (done),
        .match      (match),
        .malformed  (malformed),
        .crc_calc   (crc_calc),
        .crc_expect (crc_expect)
    );
endmodule

// File: rtl/icc_checker.sv
// Module: icc_checker
// Protocol and result properties for img_crc_check, attached by bind.
module icc_checker #(
    parameter int unsigned      CRC_W = 16,
    parameter logic [CRC_W-1:0] INIT  = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             done,
    input logic             match,
    input logic             malformed,
    input logic [CRC_W-1:0] crc_calc,
    input logic [CRC_W-1:0] crc_expect
);
    assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready);

    assert_done_follows_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> done);

    assert_done_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_last));

    assert_match_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (crc_calc == crc_expect) && !malformed);

    assert_short_crc_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        malformed |-> (crc_calc == INIT) && !match);

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(in_valid && in_last)) |=> !match && !malformed && !done);

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(in_valid && in_last)) |=>
            $stable(match) && $stable(malformed) && $stable(crc_calc) && $stable(crc_expect));
endmodule

bind img_crc_check icc_checker #(.CRC_W(CRC_W), .INIT(INIT)) u_icc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .done       (done),
    .match      (match),
    .malformed  (malformed),
    .crc_calc   (crc_calc),
    .crc_expect (crc_expect)
);

// File: tb/img_crc_check_tb.sv
module img_crc_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        done;
    logic        match;
    logic        malformed;
    logic [15:0] crc_calc;
    logic [15:0] crc_expect;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] img [MAXL];

    always #(CLK_PERIOD/2) clk = ~clk;

    img_crc_check u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .done(done), .match(match), .malformed(malformed),
        .crc_calc(crc_calc), .crc_expect(crc_expect)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference CRC over img[0..n-1]: generator 0x1021, zero seed, MSB first.
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {img[i], 8'h00};
            for (int k = 0; k < 8; k++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic beat(input logic [7:0] b, input logic l, input logic s);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = l; start = s;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0; in_data = 8'h00;
    endtask

    // Sends img[0..n-1], with optional idle gaps, then one idle cycle.
    task automatic run_image(input int n, input int gap_pct);
        for (int i = 0; i < n; i++) begin
            if (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                int g = $urandom_range(3, 1);
                for (int k = 0; k < g; k++) idle();
            end
            beat(img[i], (i == n-1), 1'b0);
        end
        idle();
    endtask

    // Checks outputs right after the last byte against values from img.
    task automatic verify(input int n);
        logic [15:0] e_calc, e_exp;
        logic        e_bad, e_match;
        if (n < 3) begin
            e_bad = 1'b1; e_calc = 16'h0000;
            e_exp = (n == 2) ? {img[0], img[1]} : {8'h00, img[0]};
            e_match = 1'b0;
        end else begin
            e_bad = 1'b0; e_calc = ref_crc(n - 2);
            e_exp = {img[n-2], img[n-1]};
            e_match = (e_calc == e_exp);
        end
        chk("R4", "done", 32'(done), 32'(1'b1));
        chk("R2", "crc_calc", 32'(crc_calc), 32'(e_calc));
        chk("R3", "crc_expect", 32'(crc_expect), 32'(e_exp));
        chk("R5", "match", 32'(match), 32'(e_match));
        chk("R6", "malformed", 32'(malformed), 32'(e_bad));
    endtask

    task automatic load_known(input logic [15:0] trailer);
        string s = "123456789";
        for (int i = 0; i < 9; i++) img[i] = s[i];
        img[9] = trailer[15:8];
        img[10] = trailer[7:0];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
        chk("R4", "done at reset", 32'(done), 32'd0);
        chk("R5", "match at reset", 32'(match), 32'd0);
        chk("R6", "malformed at reset", 32'(malformed), 32'd0);

        // Known string with correct trailer (R2 0x31C3)
        load_known(16'h31C3);
        run_image(11, 0);
        verify(11);
        chk("R2", "known CRC", 32'(crc_calc), 32'h31C3);
        idle();
        chk("R4", "done single cycle", 32'(done), 32'd0);
        // R9: results hold while idle
        repeat (4) idle();
        chk("R9", "match held", 32'(match), 32'd1);
        chk("R9", "expect held", 32'(crc_expect), 32'h31C3);

        // Swapped trailer bytes: mismatch
        load_known(16'hC331);
        run_image(11, 0);
        verify(11);
        chk("R5", "swapped trailer mismatch", 32'(match), 32'd0);

        // Length boundaries
        img[0] = 8'h00; img[1] = 8'h00;
        run_image(2, 0); verify(2);
        chk("R6", "zero two-byte malformed", 32'(malformed), 32'd1);
        img[0] = 8'hAB;
        run_image(1, 0); verify(1);
        chk("R6", "one-byte expect", 32'(crc_expect), 32'h00AB);
        img[0] = 8'h42; img[2] = 8'h00;
        begin
            logic [15:0] c1 = ref_crc(1);
            img[1] = c1[15:8]; img[2] = c1[7:0];
        end
        run_image(3, 0); verify(3);
        chk("R6", "three-byte not malformed", 32'(malformed), 32'd0);

        // Gaps inside the image (R7)
        load_known(16'h31C3);
        run_image(11, 60);
        verify(11);
        chk("R7", "gapped match", 32'(match), 32'd1);

        // Start after a partial image (R8)
        for (int i = 0; i < 5; i++) beat(8'($urandom), 1'b0, 1'b0);
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; start = 1'b1;
        idle();
        chk("R8", "start clears match", 32'(match), 32'd0);
        chk("R8", "start clears expect", 32'(crc_expect), 32'd0);
        chk("R8", "start clears calc", 32'(crc_calc), 32'd0);
        load_known(16'h31C3);
        run_image(11, 0);
        verify(11);
        chk("R8", "match after start", 32'(match), 32'd1);

        // Start together with the first byte (R8)
        for (int i = 0; i < 4; i++) beat(8'($urandom), 1'b0, 1'b0);
        beat(img[0], 1'b0, 1'b1);
        for (int i = 1; i < 11; i++) beat(img[i], (i == 10), 1'b0);
        idle();
        verify(11);
        chk("R8", "start with first byte", 32'(match), 32'd1);

        // Back-to-back images (R10)
        for (int i = 0; i < 11; i++) beat(img[i], (i == 10), 1'b0);
        beat(8'h5A, 1'b1, 1'b0);
        chk("R10", "first image match", 32'(match), 32'd1);
        chk("R10", "first image done", 32'(done), 32'd1);
        idle();
        chk("R10", "second image done", 32'(done), 32'd1);
        chk("R10", "second image malformed", 32'(malformed), 32'd1);
        chk("R10", "second image expect", 32'(crc_expect), 32'h005A);

        // Random images
        for (int t = 0; t < 40; t++) begin
            int n = $urandom_range(MAXL, 3);
            for (int i = 0; i < n; i++) img[i] = 8'($urandom);
            if ($urandom_range(1) == 1) begin
                logic [15:0] c = ref_crc(n - 2);
                img[n-2] = c[15:8]; img[n-1] = c[7:0];
            end
            run_image(n, (t % 3 == 0) ? 30 : 0);
            verify(n);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule